// File: doc/BRIEF.md
# Chained CAM Device Select Arbiter

In a chain of content-addressable memory devices that share one bus, every device sees every bus cycle. This block sits in each device and decides which of four bus actions that device takes part in: command write, data write, command read and data read. It holds two registers of its own, a select code and the device's page number. It combines them with the compare-enable state, the device's match result, the match and full signals passed along the chain, the operating mode and the class of the current instruction.

When compare-enable is off, the select code chooses the device. An all-ones code is a broadcast for writes, and a code equal to the page number addresses the device alone. When compare-enable is on, the device that holds the highest-priority match is selected. That is the device whose own match is active while no device above it matched. In the enhanced mode, writes still reach the devices that did not match. Some instruction classes override these base enables: register writes, setting the full flag, writes to the next free location, transfers of the next free address, and enhanced-mode writes aimed at the matching entry. The enables are combinational; only the two registers are clocked.

Top module: `cam_devsel_arbiter`

## Requirements
- R1: After reset the select code is all ones and the page number is zero. With compare-enable off, a plain instruction (class 0) and no destination (code 0) then give writes enabled and reads disabled.
- R2: Compare-enable off, select code all ones, plain instruction: command and data writes are enabled, and both reads are disabled.
- R3: Compare-enable off, select code equal to the page number, plain instruction: all four enables are on.
- R4: Compare-enable off, select code neither all ones nor the page number, plain instruction: all four enables are off.
- R5: Standard mode (enh_mode_i low) with compare-enable on: all four enables are on when the local match is active (match_n_i low) and match_in_n_i is high. In every other case all four are off.
- R6: Enhanced mode with compare-enable on: both writes are enabled. Both reads follow the winning condition of R5.
- R7: With mflag_en_i low, the local match counts as inactive whatever match_n_i is, so the winning condition never holds.
- R8: Instruction class 1 (write select code) always has command write enabled, and on a strobe it loads wdata_i into the select code in every device.
- R9: Instruction classes 2 (write page number) and 3 (set full flag) have command write enabled only in the first-empty device (full_in_n_i low, full_n_i high). On a strobe, class 2 loads the page number only in that device.
- R10: Instruction class 4 (move to next free) has command write, and destination code 1 (next free) has data write, forced off unless the device is the first-empty device. This takes precedence over R2–R6 and R12.
- R11: Instruction class 6 (transfer next free) has command read enabled exactly in the first-empty device.
- R12: In enhanced mode with compare-enable on and the device not winning, class 5 (move or validity change at the match) turns command write off, and destination code 2 (matching entry) turns data write off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb_i | input | 1 | Register write strobe for classes 1 and 2 |
| wdata_i | input | DW | Data for the select code or page number |
| op_i | input | 3 | Instruction class (0 plain, 1 write select, 2 write page, 3 set full, 4 move to next free, 5 move/validity at match, 6 transfer next free) |
| pdest_i | input | 2 | Standing data-write destination (0 other, 1 next free, 2 matching entry, 3 other) |
| cmp_en_i | input | 1 | Compare-enable state, active high |
| match_n_i | input | 1 | Local match flag, active low |
| match_in_n_i | input | 1 | Match from higher devices, active low |
| full_in_n_i | input | 1 | Full from higher devices, active low |
| full_n_i | input | 1 | Local full flag, active low |
| enh_mode_i | input | 1 | 1 = enhanced mode, 0 = standard |
| mflag_en_i | input | 1 | Match flag enable |
| cmd_wr_en_o | output | 1 | Command write enable |
| data_wr_en_o | output | 1 | Data write enable |
| cmd_rd_en_o | output | 1 | Command read enable |
| data_rd_en_o | output | 1 | Data read enable |

## Verification
The hardest case to reach from the ports is the own-page select. The page register only takes a write in the first-empty device, so the bench first places the device at the head of the empty part of the chain. It then loads a page number and writes the same value into the select code. A refused page write is shown by holding the chain signals elsewhere and then selecting the attempted value, which must not give reads. After that, the bench sweeps every combination of chain, mode, instruction class and destination for each of the three select states.

// File: rtl/cam_devsel_pkg.sv
package cam_devsel_pkg;
  typedef enum logic [2:0] {
    OPC_PLAIN    = 3'd0,
    OPC_WR_DSEL  = 3'd1,
    OPC_WR_PAGE  = 3'd2,
    OPC_SET_FULL = 3'd3,
    OPC_MOV_NF   = 3'd4,
    OPC_MOV_HIT  = 3'd5,
    OPC_XFER_NF  = 3'd6,
    OPC_RSVD     = 3'd7
  } opc_e;

  typedef enum logic [1:0] {
    DST_OTHER = 2'd0,
    DST_NF    = 2'd1,
    DST_HIT   = 2'd2,
    DST_RSVD  = 2'd3
  } dst_e;

  typedef struct packed {
    logic cw;
    logic dw;
    logic cr;
    logic dr;
  } en_t;
endpackage

// File: rtl/cam_devsel_chain.sv
module cam_devsel_chain (
  input  logic match_n_i,
  input  logic mflag_en_i,
  input  logic match_in_n_i,
  input  logic full_in_n_i,
  input  logic full_n_i,
  output logic winner_o,
  output logic first_empty_o
);
  logic mf_act;

  always_comb begin
    mf_act        = mflag_en_i & ~match_n_i;
    winner_o      = mf_act & match_in_n_i;
    first_empty_o = ~full_in_n_i & full_n_i;
  end
endmodule

// File: rtl/cam_devsel_regs.sv
module cam_devsel_regs
  import cam_devsel_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb_i,
  input  opc_e          op_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          first_empty_i,
  output logic [DW-1:0] sel_q_o,
  output logic [DW-1:0] page_q_o
);
  localparam logic [DW-1:0] SEL_RST  = '1;
  localparam logic [DW-1:0] PAGE_RST = '0;

  logic          sel_en, page_en;
  logic [DW-1:0] sel_d, page_d;

  always_comb begin
    sel_en  = wr_stb_i & (op_i == OPC_WR_DSEL);
    page_en = wr_stb_i & (op_i == OPC_WR_PAGE) & first_empty_i;
    sel_d   = sel_en  ? wdata_i : sel_q_o;
    page_d  = page_en ? wdata_i : page_q_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q_o  <= SEL_RST;
      page_q_o <= PAGE_RST;
    end else begin
      sel_q_o  <= sel_d;
      page_q_o <= page_d;
    end
  end

  assert_dsel_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_i && op_i == OPC_WR_DSEL) |=> (sel_q_o == $past(wdata_i)));

  assert_page_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_stb_i && op_i == OPC_WR_PAGE && first_empty_i)) |=> $stable(page_q_o));
endmodule

// File: rtl/cam_devsel_base.sv
module cam_devsel_base
  import cam_devsel_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_en_i,
  input  logic          enh_mode_i,
  input  logic          winner_i,
  input  logic [DW-1:0] sel_q_i,
  input  logic [DW-1:0] page_q_i,
  output en_t           base_o
);
  localparam logic [DW-1:0] BCAST = '1;

  logic bcast_hit, page_hit;

  always_comb begin
    bcast_hit = (sel_q_i == BCAST);
    page_hit  = (sel_q_i == page_q_i);
    base_o    = '0;
    if (!cmp_en_i) begin
      base_o.cw = bcast_hit | page_hit;
      base_o.dw = bcast_hit | page_hit;
      base_o.cr = page_hit;
      base_o.dr = page_hit;
    end else if (!enh_mode_i) begin
      base_o = {4{winner_i}};
    end else begin
      base_o.cw = 1'b1;
      base_o.dw = 1'b1;
      base_o.cr = winner_i;
      base_o.dr = winner_i;
    end
  end

  assert_std_loser_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en_i && !enh_mode_i && !winner_i) |-> (base_o == '0));

  assert_enh_writes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en_i && enh_mode_i) |-> (base_o.cw && base_o.dw));
endmodule

// File: rtl/cam_devsel_excp.sv
module cam_devsel_excp
  import cam_devsel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  en_t  base_i,
  input  opc_e op_i,
  input  dst_e dst_i,
  input  logic cmp_en_i,
  input  logic enh_mode_i,
  input  logic winner_i,
  input  logic first_empty_i,
  output en_t  en_o
);
  logic enh_loser;

  always_comb begin
    enh_loser = cmp_en_i & enh_mode_i & ~winner_i;
    en_o      = base_i;
    if (enh_loser) begin
      if (op_i == OPC_MOV_HIT) en_o.cw = 1'b0;
      if (dst_i == DST_HIT)    en_o.dw = 1'b0;
    end
    if (op_i == OPC_MOV_NF) en_o.cw = en_o.cw & first_empty_i;
    if (dst_i == DST_NF)    en_o.dw = en_o.dw & first_empty_i;
    unique case (op_i)
      OPC_WR_DSEL:               en_o.cw = 1'b1;
      OPC_WR_PAGE, OPC_SET_FULL: en_o.cw = first_empty_i;
      OPC_XFER_NF:               en_o.cr = first_empty_i;
      default: ;
    endcase
  end

  assert_nf_refuse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_i == DST_NF && !first_empty_i) |-> !en_o.dw);

  assert_hit_refuse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en_i && enh_mode_i && !winner_i && op_i == OPC_MOV_HIT) |-> !en_o.cw);
endmodule

// File: rtl/cam_devsel_arbiter.sv
module cam_devsel_arbiter
  import cam_devsel_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [2:0]    op_i,
  input  logic [1:0]    pdest_i,
  input  logic          cmp_en_i,
  input  logic          match_n_i,
  input  logic          match_in_n_i,
  input  logic          full_in_n_i,
  input  logic          full_n_i,
  input  logic          enh_mode_i,
  input  logic          mflag_en_i,
  output logic          cmd_wr_en_o,
  output logic          data_wr_en_o,
  output logic          cmd_rd_en_o,
  output logic          data_rd_en_o
);
  opc_e          op;
  dst_e          dst;
  logic          winner, first_empty;
  logic [DW-1:0] sel_q, page_q;
  en_t           base_en, fin_en;

  assign op  = opc_e'(op_i);
  assign dst = dst_e'(pdest_i);

  cam_devsel_chain chain_i (
    .match_n_i    (match_n_i),
    .mflag_en_i   (mflag_en_i),
    .match_in_n_i (match_in_n_i),
    .full_in_n_i  (full_in_n_i),
    .full_n_i     (full_n_i),
    .winner_o     (winner),
    .first_empty_o(first_empty)
  );

  cam_devsel_regs #(.DW(DW)) regs_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_stb_i     (wr_stb_i),
    .op_i         (op),
    .wdata_i      (wdata_i),
    .first_empty_i(first_empty),
    .sel_q_o      (sel_q),
    .page_q_o     (page_q)
  );

  cam_devsel_base #(.DW(DW)) base_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_en_i  (cmp_en_i),
    .enh_mode_i(enh_mode_i),
    .winner_i  (winner),
    .sel_q_i   (sel_q),
    .page_q_i  (page_q),
    .base_o    (base_en)
  );

  cam_devsel_excp excp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .base_i       (base_en),
    .op_i         (op),
    .dst_i        (dst),
    .cmp_en_i     (cmp_en_i),
    .enh_mode_i   (enh_mode_i),
    .winner_i     (winner),
    .first_empty_i(first_empty),
    .en_o         (fin_en)
  );

  assign cmd_wr_en_o  = fin_en.cw;
  assign data_wr_en_o = fin_en.dw;
  assign cmd_rd_en_o  = fin_en.cr;
  assign data_rd_en_o = fin_en.dr;

  assert_nomatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mflag_en_i && cmp_en_i && !enh_mode_i && op_i == 3'd0 && pdest_i == 2'd0)
      |-> !(cmd_wr_en_o || data_wr_en_o || cmd_rd_en_o || data_rd_en_o));

  assert_xfer_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd6) |-> (cmd_rd_en_o == (!full_in_n_i && full_n_i)));
endmodule

// File: tb/cam_devsel_arbiter_tb_top.sv
module cam_devsel_arbiter_tb_top;
  localparam int DW = 16;
  localparam logic [DW-1:0] PAGE_V  = 16'h1234;
  localparam logic [DW-1:0] OTHER_V = 16'h0042;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_stb;
  logic [DW-1:0] wdata;
  logic [2:0] op;
  logic [1:0] pd;
  logic ec, mn, min_n, fin_n, ff_n, enh, mfen;
  logic cw, dw, cr, dr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  cam_devsel_arbiter #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb), .wdata_i(wdata),
    .op_i(op), .pdest_i(pd), .cmp_en_i(ec), .match_n_i(mn),
    .match_in_n_i(min_n), .full_in_n_i(fin_n), .full_n_i(ff_n),
    .enh_mode_i(enh), .mflag_en_i(mfen),
    .cmd_wr_en_o(cw), .data_wr_en_o(dw), .cmd_rd_en_o(cr), .data_rd_en_o(dr)
  );

  // Expected {cw,dw,cr,dr} from the requirement text; sel/page are the bench's own record
  function automatic logic [3:0] expect_en(logic [DW-1:0] sel, logic [DW-1:0] page);
    logic win, fe, e_cw, e_dw, e_cr, e_dr;
    win = mfen && !mn && min_n;
    fe  = !fin_n && ff_n;
    if (!ec) begin
      e_cw = (sel == '1) || (sel == page);
      e_dw = e_cw;
      e_cr = (sel == page);
      e_dr = e_cr;
    end else if (!enh) begin
      {e_cw, e_dw, e_cr, e_dr} = {4{win}};
    end else begin
      e_cw = 1'b1; e_dw = 1'b1; e_cr = win; e_dr = win;
    end
    if (ec && enh && !win) begin
      if (op == 3'd5) e_cw = 1'b0;
      if (pd == 2'd2) e_dw = 1'b0;
    end
    if (op == 3'd4) e_cw = e_cw && fe;
    if (pd == 2'd1) e_dw = e_dw && fe;
    if (op == 3'd1) e_cw = 1'b1;
    if (op == 3'd2 || op == 3'd3) e_cw = fe;
    if (op == 3'd6) e_cr = fe;
    return {e_cw, e_dw, e_cr, e_dr};
  endfunction

  function automatic string tag_of(logic [DW-1:0] sel, logic [DW-1:0] page);
    logic win;
    win = mfen && !mn && min_n;
    if (op == 3'd6) return "R11";
    if (op == 3'd1) return "R8";
    if (op == 3'd2 || op == 3'd3) return "R9";
    if (op == 3'd4 || pd == 2'd1) return "R10";
    if (ec && enh && !win && (op == 3'd5 || pd == 2'd2)) return "R12";
    if (ec && !mfen && !mn) return "R7";
    if (!ec) begin
      if (sel == '1) return "R2";
      if (sel == page) return "R3";
      return "R4";
    end
    if (enh) return "R6";
    return "R5";
  endfunction

  task automatic check(string tag, logic [3:0] exp_v);
    n_tests++;
    if ({cw, dw, cr, dr} !== exp_v) begin
      n_fail++;
      $display("FAIL %s: en={cw,dw,cr,dr} actual %b expected %b (op=%0d pd=%0d ec=%b enh=%b mfen=%b mn=%b mi=%b fi=%b ff=%b)",
               tag, {cw, dw, cr, dr}, exp_v, op, pd, ec, enh, mfen, mn, min_n, fin_n, ff_n);
    end
  endtask

  task automatic idle_inputs();
    wr_stb = 1'b0; wdata = '0; op = 3'd0; pd = 2'd0;
    ec = 1'b0; mn = 1'b1; min_n = 1'b1; fin_n = 1'b1; ff_n = 1'b1;
    enh = 1'b0; mfen = 1'b1;
  endtask

  task automatic reg_write(logic [2:0] opc, logic [DW-1:0] v, logic fi, logic ff);
    @(negedge clk);
    op = opc; wdata = v; wr_stb = 1'b1; fin_n = fi; ff_n = ff;
    @(negedge clk);
    idle_inputs();
    #1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] sel_m;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset values: select all ones, page zero
    check("R1", 4'b1100);

    // R9: page write refused outside first-empty device (full-in high)
    reg_write(3'd2, OTHER_V, 1'b1, 1'b1);
    reg_write(3'd1, OTHER_V, 1'b1, 1'b1);
    check("R9", 4'b0000);
    // R9: refused when the device itself is full
    reg_write(3'd2, OTHER_V, 1'b0, 1'b0);
    check("R9", 4'b0000);
    // R9: accepted in first-empty device
    reg_write(3'd2, PAGE_V, 1'b0, 1'b1);
    reg_write(3'd1, PAGE_V, 1'b1, 1'b0);
    // R8: select code loaded in a full device, own page now addressed (R3)
    check("R8", 4'b1111);

    for (int s = 0; s < 3; s++) begin
      sel_m = (s == 0) ? '1 : (s == 1) ? PAGE_V : OTHER_V;
      reg_write(3'd1, sel_m, 1'b1, 1'b1);
      for (int v = 0; v < 128; v++) begin
        for (int o = 0; o < 7; o++) begin
          for (int p = 0; p < 3; p++) begin
            @(negedge clk);
            {ec, mn, min_n, fin_n, ff_n, enh, mfen} = 7'(v);
            op = 3'(o);
            pd = 2'(p);
            #1;
            check(tag_of(sel_m, PAGE_V), expect_en(sel_m, PAGE_V));
          end
        end
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule